// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the asynchronous strobes of a parallel NOR-flash style port and turns bus writes into commands. The chip-enable, write-enable and output-enable strobes (all active low) are sampled on a system clock. A write window is detected from them. The address is taken when the window opens and the data when it closes. The captured cycles are matched against the multi-cycle unlock sequences for program, chip erase, sector erase, identifier mode, reset, erase hold and erase continue.

When a sequence completes, the block sends a one-cycle start request to the embedded-operation engine. The request carries the operation kind, address and data. The engine reports completion or failure through two input pulses. The block also tells the read path what a read at the current address returns: array contents, an identifier byte, or operation status. Any malformed cycle quietly returns the decoder to plain array reading. While an embedded operation runs, the decoder accepts nothing except a hold request during an erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write cycle exists only while `ce_n` and `we_n` are both low and `oe_n` is high. A cycle with `oe_n` held low, or with `ce_n` held high, has no effect on the decoder.
- R2: The address of a write is the value present when the write window opens, that is at the later of the two strobe falls. The data is the value present on the last sampled cycle before the window closes. Later address changes and earlier data values are not used.
- R3: Unlock A is word offset 555h (low 11 bits) with data AAh. Unlock B is 2AAh with 55h. Unlock A, unlock B, then A0h at 555h, then any address/data write, pulses `op_start` with `op_kind` = 01, and `op_addr`/`op_data` equal to that last write. That last write accepts every data value, including F0h. `busy` is then high until `op_done`.
- R4: Unlock A, unlock B, 80h at 555h, unlock A, unlock B, then 10h at 555h starts a chip erase (`op_kind` = 10). If the final write is instead 30h at any address, it starts a sector erase (`op_kind` = 11) of the sector named by that address.
- R5: Unlock A, unlock B, then 90h at 555h selects identifier reads (`rd_src` = 01). On `id_data`, word offset 00h gives 01h, word offset 01h gives 5Ch, word offset 02h gives 01h if that sector's `sect_prot` bit is set and 00h otherwise, and every other offset gives 00h. In byte mode (`byte_mode` = 1), every address is a byte address, twice the word offset. Writes other than F0h leave this mode unchanged.
- R6: A write whose address or data does not match the next expected cycle returns the decoder to array reading (`rd_src` = 00) without a start request.
- R7: F0h written at any address ends a sequence in progress, identifier mode, or failure mode, and returns to array reading.
- R8: While `busy` is high, every write other than a B0h hold request during an erase is ignored. `busy` stays high, no request is issued, and reads return status (`rd_src` = 10).
- R9: An `op_fail` pulse while busy enters a failure mode: `busy` goes low and reads return status at every address. Only R7's reset leaves this mode.
- R10: B0h during an erase pulses `op_suspend` and drops `busy`. Reads inside the erased sector (every address for chip erase) then return status, and other reads return array. A full program sequence may run in this held state and returns to it on `op_done`. 30h pulses `op_resume` and raises `busy` again.
- R11: After reset the decoder reads array, `busy` is low, and no request pulses appear.
- R12: While `vcc_low` is high, the decoder is held in array reading and every write is discarded. Nothing written during that time has an effect afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, also the hardware reset |
| vcc_low | input | 1 | Supply lockout, forces array reading |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1: byte addressing, 0: word addressing |
| addr | input | ADDR_W+1 | Bus address; bit 0 is the byte select in byte mode |
| wdata | input | DATA_W | Bus write data; command bytes use bits 7:0 |
| op_done | input | 1 | Engine completion pulse |
| op_fail | input | 1 | Engine failure pulse |
| sect_prot | input | 2**SECT_BITS | Protection flag per sector |
| op_start | output | 1 | One-cycle start request |
| op_kind | output | 2 | 01 program, 10 chip erase, 11 sector erase |
| op_addr | output | ADDR_W+1 | Address of the start request |
| op_data | output | DATA_W | Program data of the start request |
| op_suspend | output | 1 | One-cycle erase hold request |
| op_resume | output | 1 | One-cycle erase continue request |
| busy | output | 1 | Embedded operation running |
| rd_src | output | 2 | Read source: 00 array, 01 identifier, 10 status |
| id_data | output | 8 | Identifier byte for the current address |

## Verification
The bench uses the default parameters: a 17-bit word address, 16-bit data, and eight sectors selected by the top three word-address bits. With these values the unlock offsets in the low eleven bits are disjoint from the sector field, so one write can carry a sector choice and a don't-care offset together. Byte mode reuses the same word offsets shifted by one, which makes both identifier address maps reachable. The protection flags of two sectors differ, so the protection read must pick the sector named by the address.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int FCD_ADDR_W    = 17;
    localparam int FCD_DATA_W    = 16;
    localparam int FCD_SECT_BITS = 3;

    localparam int UNLK_W = 11;
    localparam logic [UNLK_W-1:0] UNLK_ADDR_A = 11'h555;
    localparam logic [UNLK_W-1:0] UNLK_ADDR_B = 11'h2AA;

    localparam logic [7:0] KEY_A      = 8'hAA;
    localparam logic [7:0] KEY_B      = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECTOR = 8'h30;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_HOLD   = 8'hB0;
    localparam logic [7:0] CMD_CONT   = 8'h30;

    localparam logic [7:0] ID_MAKER  = 8'h01;
    localparam logic [7:0] ID_PART   = 8'h5C;
    localparam logic [7:0] OFS_MAKER = 8'h00;
    localparam logic [7:0] OFS_PART  = 8'h01;
    localparam logic [7:0] OFS_PROT  = 8'h02;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_CHIP = 2'b10,
        OP_SECT = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'b00,
        SRC_IDENT  = 2'b01,
        SRC_STATUS = 2'b10
    } rd_src_e;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PSET,
        ST_ESET,
        ST_EUNL1,
        ST_EUNL2,
        ST_AUTO,
        ST_PBUSY,
        ST_EBUSY,
        ST_HOLD,
        ST_HUNL1,
        ST_HUNL2,
        ST_HPSET,
        ST_HPBUSY,
        ST_FAIL
    } seq_st_e;

endpackage

// File: rtl/fcd_strobe_capture.sv
module fcd_strobe_capture
    import fcd_pkg::*;
#(
    parameter int AW = FCD_ADDR_W,
    parameter int DW = FCD_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW:0]   addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_valid,
    output logic [AW:0]   wr_addr,
    output logic [DW-1:0] wr_data
);

    typedef struct packed {
        logic          ce;
        logic          we;
        logic          oe;
        logic [AW:0]   addr_s;
        logic [DW-1:0] data_s;
        logic [DW-1:0] data_prev;
        logic          wact;
        logic [AW:0]   addr_lat;
        logic          vld;
        logic [AW:0]   out_addr;
        logic [DW-1:0] out_data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic win;

    always_comb begin
        cap_d           = cap_q;
        cap_d.ce        = ~ce_n;
        cap_d.we        = ~we_n;
        cap_d.oe        = ~oe_n;
        cap_d.addr_s    = addr;
        cap_d.data_s    = wdata;
        cap_d.data_prev = cap_q.data_s;
        win             = cap_q.ce & cap_q.we & ~cap_q.oe;
        cap_d.wact      = win;
        cap_d.vld       = 1'b0;
        if (win && !cap_q.wact) begin
            cap_d.addr_lat = cap_q.addr_s;
        end
        if (!win && cap_q.wact) begin
            cap_d.vld      = 1'b1;
            cap_d.out_addr = cap_q.addr_lat;
            cap_d.out_data = cap_q.data_prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_valid = cap_q.vld;
    assign wr_addr  = cap_q.out_addr;
    assign wr_data  = cap_q.out_data;

    // R1
    oe_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.oe && cap_q.wact == 1'b0) |=> !cap_q.wact);

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int AW = FCD_ADDR_W,
    parameter int DW = FCD_DATA_W,
    parameter int SB = FCD_SECT_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vcc_low,
    input  logic          byte_mode,
    input  logic          wr_valid,
    input  logic [AW:0]   wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          op_done,
    input  logic          op_fail,
    output logic          op_start,
    output op_kind_e      op_kind,
    output logic [AW:0]   op_addr,
    output logic [DW-1:0] op_data,
    output logic          op_suspend,
    output logic          op_resume,
    output logic          busy,
    output seq_st_e       st,
    output logic          er_all,
    output logic [SB-1:0] er_sec
);

    typedef struct packed {
        seq_st_e       st;
        logic          start;
        op_kind_e      kind;
        logic [AW:0]   addr;
        logic [DW-1:0] data;
        logic          hold;
        logic          cont;
        logic          er_all;
        logic [SB-1:0] er_sec;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [AW-1:0] waddr;
    logic [7:0]    cmd;
    logic          hit_a;
    logic          hit_b;
    logic          key1;
    logic          key2;
    logic          is_reset;

    assign waddr    = byte_mode ? wr_addr[AW:1] : wr_addr[AW-1:0];
    assign cmd      = wr_data[7:0];
    assign hit_a    = (waddr[UNLK_W-1:0] == UNLK_ADDR_A);
    assign hit_b    = (waddr[UNLK_W-1:0] == UNLK_ADDR_B);
    assign key1     = hit_a && (cmd == KEY_A);
    assign key2     = hit_b && (cmd == KEY_B);
    assign is_reset = (cmd == CMD_RESET);

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.hold  = 1'b0;
        seq_d.cont  = 1'b0;
        if (vcc_low) begin
            seq_d.st = ST_READ;
        end else begin
            unique case (seq_q.st)
                ST_READ: begin
                    if (wr_valid && key1) seq_d.st = ST_UNL1;
                end
                ST_UNL1: begin
                    if (wr_valid) seq_d.st = key2 ? ST_UNL2 : ST_READ;
                end
                ST_UNL2: begin
                    if (wr_valid) begin
                        if (hit_a && cmd == CMD_PROG)       seq_d.st = ST_PSET;
                        else if (hit_a && cmd == CMD_ERASE) seq_d.st = ST_ESET;
                        else if (hit_a && cmd == CMD_IDENT) seq_d.st = ST_AUTO;
                        else                                seq_d.st = ST_READ;
                    end
                end
                ST_PSET, ST_HPSET: begin
                    if (wr_valid) begin
                        seq_d.start = 1'b1;
                        seq_d.kind  = OP_PROG;
                        seq_d.addr  = wr_addr;
                        seq_d.data  = wr_data;
                        seq_d.st    = (seq_q.st == ST_PSET) ? ST_PBUSY : ST_HPBUSY;
                    end
                end
                ST_ESET: begin
                    if (wr_valid) seq_d.st = key1 ? ST_EUNL1 : ST_READ;
                end
                ST_EUNL1: begin
                    if (wr_valid) seq_d.st = key2 ? ST_EUNL2 : ST_READ;
                end
                ST_EUNL2: begin
                    if (wr_valid) begin
                        if (hit_a && cmd == CMD_CHIP) begin
                            seq_d.start  = 1'b1;
                            seq_d.kind   = OP_CHIP;
                            seq_d.addr   = wr_addr;
                            seq_d.data   = wr_data;
                            seq_d.er_all = 1'b1;
                            seq_d.st     = ST_EBUSY;
                        end else if (cmd == CMD_SECTOR) begin
                            seq_d.start  = 1'b1;
                            seq_d.kind   = OP_SECT;
                            seq_d.addr   = wr_addr;
                            seq_d.data   = wr_data;
                            seq_d.er_all = 1'b0;
                            seq_d.er_sec = waddr[AW-1 -: SB];
                            seq_d.st     = ST_EBUSY;
                        end else begin
                            seq_d.st = ST_READ;
                        end
                    end
                end
                ST_AUTO: begin
                    if (wr_valid && is_reset) seq_d.st = ST_READ;
                end
                ST_PBUSY: begin
                    if (op_fail)      seq_d.st = ST_FAIL;
                    else if (op_done) seq_d.st = ST_READ;
                end
                ST_EBUSY: begin
                    if (op_fail)      seq_d.st = ST_FAIL;
                    else if (op_done) seq_d.st = ST_READ;
                    else if (wr_valid && cmd == CMD_HOLD) begin
                        seq_d.hold = 1'b1;
                        seq_d.st   = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (wr_valid) begin
                        if (key1) begin
                            seq_d.st = ST_HUNL1;
                        end else if (cmd == CMD_CONT) begin
                            seq_d.cont = 1'b1;
                            seq_d.st   = ST_EBUSY;
                        end
                    end
                end
                ST_HUNL1: begin
                    if (wr_valid) seq_d.st = key2 ? ST_HUNL2 : ST_HOLD;
                end
                ST_HUNL2: begin
                    if (wr_valid) seq_d.st = (hit_a && cmd == CMD_PROG) ? ST_HPSET : ST_HOLD;
                end
                ST_HPBUSY: begin
                    if (op_fail)      seq_d.st = ST_FAIL;
                    else if (op_done) seq_d.st = ST_HOLD;
                end
                ST_FAIL: begin
                    if (wr_valid && is_reset) seq_d.st = ST_READ;
                end
                default: seq_d.st = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_READ;
            seq_q.kind <= OP_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign op_start   = seq_q.start;
    assign op_kind    = seq_q.kind;
    assign op_addr    = seq_q.addr;
    assign op_data    = seq_q.data;
    assign op_suspend = seq_q.hold;
    assign op_resume  = seq_q.cont;
    assign st         = seq_q.st;
    assign er_all     = seq_q.er_all;
    assign er_sec     = seq_q.er_sec;
    assign busy       = (seq_q.st == ST_PBUSY) || (seq_q.st == ST_EBUSY) ||
                        (seq_q.st == ST_HPBUSY);

    // R12
    lockout_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_low |=> (st == ST_READ && !op_start));

    // R8
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PBUSY && wr_valid && !op_done && !op_fail && !vcc_low) |=> busy);

    // R3
    start_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> ($past(st) == ST_PSET || $past(st) == ST_HPSET || $past(st) == ST_EUNL2));

    // R10
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_start, op_suspend, op_resume}));

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && !(wr_valid && cmd == CMD_RESET) && !vcc_low) |=> st == ST_FAIL);

endmodule

// File: rtl/fcd_read_sel.sv
module fcd_read_sel
    import fcd_pkg::*;
#(
    parameter int AW = FCD_ADDR_W,
    parameter int SB = FCD_SECT_BITS
) (
    input  seq_st_e           st,
    input  logic              er_all,
    input  logic [SB-1:0]     er_sec,
    input  logic              byte_mode,
    input  logic [AW:0]       rd_addr,
    input  logic [(1<<SB)-1:0] sect_prot,
    output rd_src_e           rd_src,
    output logic [7:0]        id_data
);

    logic [AW-1:0] waddr;
    logic [SB-1:0] sec;
    logic [7:0]    ofs;
    logic          in_erase;

    assign waddr    = byte_mode ? rd_addr[AW:1] : rd_addr[AW-1:0];
    assign sec      = waddr[AW-1 -: SB];
    assign ofs      = waddr[7:0];
    assign in_erase = er_all || (sec == er_sec);

    always_comb begin
        unique case (st)
            ST_AUTO:                                  rd_src = SRC_IDENT;
            ST_PBUSY, ST_EBUSY, ST_HPBUSY, ST_FAIL:   rd_src = SRC_STATUS;
            ST_HOLD, ST_HUNL1, ST_HUNL2, ST_HPSET:    rd_src = in_erase ? SRC_STATUS : SRC_ARRAY;
            default:                                  rd_src = SRC_ARRAY;
        endcase
    end

    always_comb begin
        id_data = 8'h00;
        if (st == ST_AUTO) begin
            if (ofs == OFS_MAKER)     id_data = ID_MAKER;
            else if (ofs == OFS_PART) id_data = ID_PART;
            else if (ofs == OFS_PROT) id_data = {7'b0, sect_prot[sec]};
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W    = FCD_ADDR_W,
    parameter int DATA_W    = FCD_DATA_W,
    parameter int SECT_BITS = FCD_SECT_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vcc_low,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic                    byte_mode,
    input  logic [ADDR_W:0]         addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    op_done,
    input  logic                    op_fail,
    input  logic [(1<<SECT_BITS)-1:0] sect_prot,
    output logic                    op_start,
    output logic [1:0]              op_kind,
    output logic [ADDR_W:0]         op_addr,
    output logic [DATA_W-1:0]       op_data,
    output logic                    op_suspend,
    output logic                    op_resume,
    output logic                    busy,
    output logic [1:0]              rd_src,
    output logic [7:0]              id_data
);

    logic              wr_valid;
    logic [ADDR_W:0]   wr_addr;
    logic [DATA_W-1:0] wr_data;
    seq_st_e           st;
    logic              er_all;
    logic [SECT_BITS-1:0] er_sec;
    op_kind_e          kind;
    rd_src_e           src;

    fcd_strobe_capture #(.AW(ADDR_W), .DW(DATA_W)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    fcd_seq_fsm #(.AW(ADDR_W), .DW(DATA_W), .SB(SECT_BITS)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcc_low    (vcc_low),
        .byte_mode  (byte_mode),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .op_done    (op_done),
        .op_fail    (op_fail),
        .op_start   (op_start),
        .op_kind    (kind),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .op_suspend (op_suspend),
        .op_resume  (op_resume),
        .busy       (busy),
        .st         (st),
        .er_all     (er_all),
        .er_sec     (er_sec)
    );

    fcd_read_sel #(.AW(ADDR_W), .SB(SECT_BITS)) rsel_i (
        .st        (st),
        .er_all    (er_all),
        .er_sec    (er_sec),
        .byte_mode (byte_mode),
        .rd_addr   (addr),
        .sect_prot (sect_prot),
        .rd_src    (src),
        .id_data   (id_data)
    );

    assign op_kind = kind;
    assign rd_src  = src;

    // R8
    status_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_src == SRC_STATUS);

    // R5
    ident_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src == SRC_IDENT) |-> !busy);

    // R3
    start_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> op_kind != OP_NONE);

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    import fcd_pkg::*;

    localparam int AW = FCD_ADDR_W;
    localparam int DW = FCD_DATA_W;
    localparam int SB = FCD_SECT_BITS;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, vcc_low = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic byte_m = 1'b0;
    logic [AW:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic op_done = 1'b0, op_fail = 1'b0;
    logic [(1<<SB)-1:0] sect_prot = 8'b0010_0000;
    logic op_start, op_suspend, op_resume, busy;
    logic [1:0] op_kind, rd_src;
    logic [AW:0] op_addr;
    logic [DW-1:0] op_data;
    logic [7:0] id_data;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .vcc_low(vcc_low), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .byte_mode(byte_m), .addr(addr), .wdata(wdata),
        .op_done(op_done), .op_fail(op_fail), .sect_prot(sect_prot),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .op_suspend(op_suspend), .op_resume(op_resume),
        .busy(busy), .rd_src(rd_src), .id_data(id_data)
    );

    int n_chk = 0, n_fail = 0;
    int n_start = 0, n_susp = 0, n_res = 0;
    logic [1:0] last_kind = 2'b00;
    logic [AW:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (op_start) begin
                n_start   <= n_start + 1;
                last_kind <= op_kind;
                last_addr <= op_addr;
                last_data <= op_data;
            end
            if (op_suspend) n_susp <= n_susp + 1;
            if (op_resume)  n_res  <= n_res + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW:0] raw(input int wa);
        logic [AW:0] r;
        r = (AW+1)'(wa);
        return byte_m ? (r << 1) : r;
    endfunction

    // how: 0 CE first, 3 WE first, 1 OE held low, 2 CE held high
    task automatic bw(input int wa, input logic [15:0] d, input int how = 0);
        logic [AW:0] ra;
        ra = raw(wa);
        @(negedge clk);
        addr  = ra;
        wdata = ~d;
        case (how)
            1: begin oe_n = 1'b0; ce_n = 1'b0; @(negedge clk); we_n = 1'b0; end
            2: begin we_n = 1'b0; end
            3: begin we_n = 1'b0; @(negedge clk); ce_n = 1'b0; end
            default: begin ce_n = 1'b0; @(negedge clk); we_n = 1'b0; end
        endcase
        repeat (2) @(negedge clk);
        addr  = ~ra;
        wdata = d;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic rchk(input string tag, input int wa, input logic [1:0] esrc, input logic [7:0] eid);
        @(negedge clk);
        addr = raw(wa);
        ce_n = 1'b0;
        oe_n = 1'b0;
        #1;
        chk({tag, " rd_src"}, 32'(rd_src), 32'(esrc));
        chk({tag, " id_data"}, 32'(id_data), 32'(eid));
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    task automatic unlock(input int how = 0);
        bw(32'h555, 16'h00AA, how);
        bw(32'h2AA, 16'h0055, how);
    endtask

    task automatic pulse(input bit fail);
        @(negedge clk);
        if (fail) op_fail = 1'b1; else op_done = 1'b1;
        @(negedge clk);
        op_fail = 1'b0;
        op_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int es;
        es = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11 reset state
        chk("R11 busy", 32'(busy), 0);
        rchk("R11 read", 32'h100, 2'b00, 8'h00);
        chk("R11 starts", 32'(n_start), 0);

        // R3 R2 program, word mode
        unlock();
        bw(32'h555, 16'h00A0);
        bw(32'h1234, 16'hBEEF);
        es++;
        chk("R3 start count", 32'(n_start), 32'(es));
        chk("R3 kind", 32'(last_kind), 32'h1);
        chk("R2 addr", 32'(last_addr), 32'h1234);
        chk("R2 data", 32'(last_data), 32'hBEEF);
        chk("R3 busy", 32'(busy), 1);
        rchk("R8 status read", 32'h40, 2'b10, 8'h00);
        // R8 writes ignored while busy
        bw(32'h777, 16'h00F0);
        unlock();
        bw(32'h555, 16'h00A0);
        bw(32'h2000, 16'h1111);
        chk("R8 busy kept", 32'(busy), 1);
        chk("R8 no start", 32'(n_start), 32'(es));
        pulse(1'b0);
        chk("R3 done busy", 32'(busy), 0);
        rchk("R3 array after", 32'h40, 2'b00, 8'h00);

        // R2 WE falls first, CE later; F0 accepted as program data (R3)
        unlock(3);
        bw(32'h555, 16'h00A0, 3);
        bw(32'h0ABC, 16'h00F0, 3);
        es++;
        chk("R2 we-first start", 32'(n_start), 32'(es));
        chk("R2 we-first addr", 32'(last_addr), 32'h0ABC);
        chk("R3 F0 as data", 32'(last_data), 32'h00F0);
        pulse(1'b0);

        // R5 identifier mode, word addressing
        unlock();
        bw(32'h555, 16'h0090);
        rchk("R5 maker", 32'h0, 2'b01, 8'h01);
        rchk("R5 part", 32'h1, 2'b01, 8'h5C);
        rchk("R5 prot set", (5 << 14) | 2, 2'b01, 8'h01);
        rchk("R5 prot clear", (2 << 14) | 2, 2'b01, 8'h00);
        rchk("R5 other ofs", 32'h3, 2'b01, 8'h00);
        bw(32'h555, 16'h00AA);
        rchk("R5 stays", 32'h0, 2'b01, 8'h01);
        bw(32'h123, 16'h00F0);
        rchk("R7 exit ident", 32'h0, 2'b00, 8'h00);

        // R5 byte addressing
        byte_m = 1'b1;
        unlock();
        bw(32'h555, 16'h0090);
        rchk("R5 byte part", 32'h1, 2'b01, 8'h5C);
        rchk("R5 byte prot", (5 << 14) | 2, 2'b01, 8'h01);
        bw(32'h0, 16'h00F0);
        byte_m = 1'b0;

        // R6 wrong data in second unlock
        bw(32'h555, 16'h00AA);
        bw(32'h2AA, 16'h0054);
        bw(32'h555, 16'h00A0);
        bw(32'h3000, 16'h2222);
        chk("R6 bad data no start", 32'(n_start), 32'(es));
        rchk("R6 bad data array", 32'h3000, 2'b00, 8'h00);
        // R6 out of order
        bw(32'h2AA, 16'h0055);
        bw(32'h555, 16'h00A0);
        bw(32'h3000, 16'h2222);
        chk("R6 order no start", 32'(n_start), 32'(es));
        // R6 wrong address for command
        unlock();
        bw(32'h556, 16'h0090);
        rchk("R6 bad addr array", 32'h0, 2'b00, 8'h00);

        // R7 reset between cycles
        unlock();
        bw(32'h1F0F, 16'h00F0);
        bw(32'h555, 16'h00A0);
        bw(32'h3000, 16'h3333);
        chk("R7 abort no start", 32'(n_start), 32'(es));

        // R4 R10 chip erase with hold
        unlock();
        bw(32'h555, 16'h0080);
        unlock();
        bw(32'h555, 16'h0010);
        es++;
        chk("R4 chip start", 32'(n_start), 32'(es));
        chk("R4 chip kind", 32'(last_kind), 32'h2);
        bw(32'h0, 16'h00B0);
        chk("R10 hold pulse", 32'(n_susp), 1);
        chk("R10 hold busy", 32'(busy), 0);
        rchk("R10 chip status", 32'h18000, 2'b10, 8'h00);
        bw(32'h0, 16'h0030);
        chk("R10 resume pulse", 32'(n_res), 1);
        chk("R10 resume busy", 32'(busy), 1);
        pulse(1'b0);
        rchk("R4 chip done", 32'h0, 2'b00, 8'h00);

        // R4 R10 sector erase, program while held
        unlock();
        bw(32'h555, 16'h0080);
        unlock();
        bw(3 << 14, 16'h0030);
        es++;
        chk("R4 sector kind", 32'(last_kind), 32'h3);
        chk("R4 sector addr", 32'(last_addr), 32'(3 << 14));
        bw(32'h0, 16'h00B0);
        rchk("R10 erased sector", (3 << 14) | 16'h10, 2'b10, 8'h00);
        rchk("R10 other sector", 6 << 14, 2'b00, 8'h00);
        unlock();
        bw(32'h555, 16'h00A0);
        bw((6 << 14) | 4, 16'h1357);
        es++;
        chk("R10 held program", 32'(n_start), 32'(es));
        chk("R10 held program busy", 32'(busy), 1);
        pulse(1'b0);
        chk("R10 back to hold", 32'(busy), 0);
        rchk("R10 hold again", (3 << 14), 2'b10, 8'h00);
        bw(32'h0, 16'h0030);
        chk("R10 second resume", 32'(n_res), 2);
        pulse(1'b0);
        rchk("R10 erase done", (3 << 14), 2'b00, 8'h00);

        // R9 failure
        unlock();
        bw(32'h555, 16'h00A0);
        bw(32'h100, 16'h00FF);
        es++;
        pulse(1'b1);
        chk("R9 busy low", 32'(busy), 0);
        rchk("R9 status", 32'h5000, 2'b10, 8'h00);
        bw(32'h555, 16'h00AA);
        rchk("R9 sticky", 32'h0, 2'b10, 8'h00);
        bw(32'h777, 16'h00F0);
        rchk("R9 cleared", 32'h0, 2'b00, 8'h00);

        // R1 inhibited writes
        unlock(1);
        bw(32'h555, 16'h0090, 1);
        rchk("R1 oe low inhibits", 32'h0, 2'b00, 8'h00);
        unlock(2);
        bw(32'h555, 16'h0090, 2);
        rchk("R1 ce high inhibits", 32'h0, 2'b00, 8'h00);

        // R12 supply lockout
        unlock();
        bw(32'h555, 16'h0090);
        rchk("R12 pre ident", 32'h0, 2'b01, 8'h01);
        @(negedge clk);
        vcc_low = 1'b1;
        @(negedge clk);
        rchk("R12 forced array", 32'h0, 2'b00, 8'h00);
        unlock();
        bw(32'h555, 16'h0090);
        @(negedge clk);
        vcc_low = 1'b0;
        rchk("R12 writes dropped", 32'h0, 2'b00, 8'h00);
        chk("R12 no start", 32'(n_start), 32'(es));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule